// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This block lets a core issue byte and word loads and stores at byte addresses against a memory that is organised as whole 16-bit words. For each request it forms the effective address from a base value and a signed 6-bit offset. For a word access the offset is scaled by two; for a byte access it is used as it stands. The block then presents a word-aligned address to memory. For a store it drives per-byte write enables and the store data already placed in the correct lanes. For a load it takes the returned memory word, picks the addressed lane, sign-extends it, and reports the result with an N/Z/P condition code.

The unit has two register stages. A request presented in cycle t appears on the memory-side outputs in cycle t+1. The memory is expected to return read data combinationally in that same cycle, and writes take effect at the end of it. The load result and its condition code appear in cycle t+2. A new request can be accepted in every cycle.

A word access whose effective address is odd is not rejected. The unit carries it out at the word address rounded down and raises an error flag for that access.

Top module: `lsa_unit`

## Requirements
- R1: The effective address is `req_base + sext(req_off)` for a byte access and `req_base + (sext(req_off) << 1)` for a word access, using 16-bit wrap-around arithmetic.
- R2: One cycle after an accepted request, `mem_req` is 1 and `mem_addr` equals the effective address with bit 0 cleared.
- R3: For a byte store, `mem_byte_we` has exactly one bit set. Bit 0 (data bits [7:0]) is set when effective address bit 0 is 0, and bit 1 (bits [15:8]) is set when it is 1. `mem_wdata` carries `req_src[7:0]` in both lanes, so the other byte in memory keeps its value.
- R4: A word store asserts `mem_byte_we = 2'b11`, and `mem_wdata` equals `req_src` unchanged.
- R5: A load drives `mem_byte_we = 2'b00`.
- R6: Two cycles after a byte load request, `ld_valid` is 1 and `ld_data` is the selected byte of `mem_rdata`, sign-extended from its bit 7 to 16 bits.
- R7: Two cycles after a word load request, `ld_valid` is 1 and `ld_data` equals the memory word read at `mem_addr`.
- R8: While `ld_valid` is 1, `ld_cc` is one-hot. Bit 2 set means N (`ld_data` is negative), bit 1 set means Z (`ld_data` is zero), and bit 0 set means P (`ld_data` is positive).
- R9: A word access with effective address bit 0 equal to 1 sets `misalign` in the same cycle as its `mem_req`. The access still proceeds at the rounded-down word address. Byte accesses never set `misalign`.
- R10: During reset and in the first cycle after it, `mem_req`, `mem_byte_we`, `misalign` and `ld_valid` are all 0.
- R11: A cycle with `req_valid` low produces `mem_req = 0` and `mem_byte_we = 0` one cycle later, and `ld_valid = 0` two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_base | input | 16 | Base address |
| req_off | input | 6 | Signed offset |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_write | input | 1 | 1 = store, 0 = load |
| req_src | input | 16 | Store source data |
| mem_rdata | input | 16 | Memory read word for the current `mem_addr` |
| mem_req | output | 1 | Memory access this cycle |
| mem_addr | output | 16 | Word-aligned byte address |
| mem_byte_we | output | 2 | Per-lane write enables |
| mem_wdata | output | 16 | Lane-aligned store data |
| misalign | output | 1 | Odd word access, rounded down |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 16 | Load result |
| ld_cc | output | 3 | N/Z/P one-hot code |

## Verification
A load result leaves the second stage in the same cycle that the next request drives a store at the first stage. The difficult case is a store to the same word that a load has just read, or a load issued right after a store to the same word. The bench provokes both by running back-to-back random requests confined to a small address window, mixed with directed store-then-load and load-then-store pairs that share a word and differ in lane. A reference memory in the bench is updated in request order. Each load is judged against the word that this memory held when the load passed the memory stage, so a result taken too early or too late reads the wrong lane value.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    localparam int CC_W = 3;
    localparam int CC_N_BIT = 2;
    localparam int CC_Z_BIT = 1;
    localparam int CC_P_BIT = 0;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/lsa_agen.sv
module lsa_agen #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 6,
    parameter int LSB_W  = 1
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  off,
    input  logic              byte_acc,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LSB_W-1:0]  lane,
    output logic              misalign
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] ea;

    always_comb begin
        off_ext   = {{EXT_W{off[OFF_W-1]}}, off};
        ea        = byte_acc ? (base + off_ext) : (base + (off_ext << LSB_W));
        lane      = ea[LSB_W-1:0];
        word_addr = {ea[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
        misalign  = !byte_acc && (ea[LSB_W-1:0] != '0);
    end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int LSB_W  = 1
) (
    input  logic              write,
    input  logic              byte_acc,
    input  logic [LSB_W-1:0]  lane,
    input  logic [DATA_W-1:0] src,
    output logic [LANES-1:0]  we,
    output logic [DATA_W-1:0] wdata
);
    import lsa_pkg::*;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (!write) begin
                we[g] = 1'b0;
            end else if (byte_acc) begin
                we[g] = (lane == LSB_W'(g));
            end else begin
                we[g] = 1'b1;
            end
            wdata[g*BYTE_W +: BYTE_W] = byte_acc ? src[BYTE_W-1:0]
                                                 : src[g*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int LSB_W  = 1
) (
    input  logic                     byte_acc,
    input  logic [LSB_W-1:0]         lane,
    input  logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        data,
    output logic [lsa_pkg::CC_W-1:0] cc
);
    import lsa_pkg::*;

    logic [BYTE_W-1:0] lane_bytes [LANES];
    logic [BYTE_W-1:0] sel;

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_bytes[g] = rdata[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        sel  = lane_bytes[lane];
        data = byte_acc ? {{(DATA_W-BYTE_W){sel[BYTE_W-1]}}, sel} : rdata;
        cc   = '0;
        if (data[DATA_W-1]) begin
            cc[CC_N_BIT] = 1'b1;
        end else if (data == '0) begin
            cc[CC_Z_BIT] = 1'b1;
        end else begin
            cc[CC_P_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int OFF_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_base,
    input  logic [OFF_W-1:0]         req_off,
    input  logic                     req_byte,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_src,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     mem_req,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W/8-1:0]      mem_byte_we,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic                     misalign,
    output logic                     ld_valid,
    output logic [DATA_W-1:0]        ld_data,
    output logic [lsa_pkg::CC_W-1:0] ld_cc
);
    import lsa_pkg::*;

    localparam int LANES = DATA_W / BYTE_W;
    localparam int LSB_W = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        logic              req;
        logic              write;
        logic              byte_acc;
        logic [LSB_W-1:0]  lane;
        logic              misalign;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  we;
        logic [DATA_W-1:0] wdata;
    } mem_stage_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CC_W-1:0]   cc;
    } ld_stage_t;

    mem_stage_t ms_d, ms_q;
    ld_stage_t  ls_d, ls_q;

    logic [ADDR_W-1:0] ag_addr;
    logic [LSB_W-1:0]  ag_lane;
    logic              ag_mis;
    logic [LANES-1:0]  sl_we;
    logic [DATA_W-1:0] sl_wdata;
    logic [DATA_W-1:0] lx_data;
    logic [CC_W-1:0]   lx_cc;

    lsa_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LSB_W(LSB_W)) u_agen (
        .base(req_base), .off(req_off), .byte_acc(req_byte),
        .word_addr(ag_addr), .lane(ag_lane), .misalign(ag_mis)
    );

    lsa_store_lanes #(.DATA_W(DATA_W), .LANES(LANES), .LSB_W(LSB_W)) u_store (
        .write(req_write), .byte_acc(req_byte), .lane(ag_lane), .src(req_src),
        .we(sl_we), .wdata(sl_wdata)
    );

    lsa_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .LSB_W(LSB_W)) u_load (
        .byte_acc(ms_q.byte_acc), .lane(ms_q.lane), .rdata(mem_rdata),
        .data(lx_data), .cc(lx_cc)
    );

    always_comb begin
        ms_d          = '0;
        ms_d.req      = req_valid;
        ms_d.write    = req_write;
        ms_d.byte_acc = req_byte;
        ms_d.lane     = ag_lane;
        ms_d.addr     = ag_addr;
        ms_d.wdata    = sl_wdata;
        ms_d.misalign = req_valid && ag_mis;
        ms_d.we       = req_valid ? sl_we : '0;

        ls_d          = '0;
        ls_d.valid    = ms_q.req && !ms_q.write;
        ls_d.data     = lx_data;
        ls_d.cc       = lx_cc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_q <= '0;
            ls_q <= '0;
        end else begin
            ms_q <= ms_d;
            ls_q <= ls_d;
        end
    end

    assign mem_req     = ms_q.req;
    assign mem_addr    = ms_q.addr;
    assign mem_byte_we = ms_q.we;
    assign mem_wdata   = ms_q.wdata;
    assign misalign    = ms_q.misalign;
    assign ld_valid    = ls_q.valid;
    assign ld_data     = ls_q.data;
    assign ld_cc       = ls_q.cc;

    p_idle_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> (mem_byte_we == '0) && !misalign);

    p_load_no_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !ms_q.write) |-> (mem_byte_we == '0));

    p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ms_q.write && ms_q.byte_acc) |-> ($countones(mem_byte_we) == 1));

    p_word_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && ms_q.write && !ms_q.byte_acc) |-> (mem_byte_we == {LANES{1'b1}}));

    p_load_result_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !ms_q.write) |=> ld_valid);

    p_cc_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($countones(ld_cc) == 1));

    p_misalign_word_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_req && !ms_q.byte_acc));

    p_addr_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[LSB_W-1:0] == '0));
endmodule

// File: tb/lsa_unit_bench.sv
`timescale 1ns/1ps
module lsa_unit_bench;
    localparam int MEM_WORDS = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_base = '0;
    logic [5:0]  req_off = '0;
    logic        req_byte = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_src = '0;
    logic [15:0] mem_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [1:0]  mem_byte_we;
    logic [15:0] mem_wdata;
    logic        misalign;
    logic        ld_valid;
    logic [15:0] ld_data;
    logic [2:0]  ld_cc;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    lsa_unit u_lsa_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_off(req_off), .req_byte(req_byte), .req_write(req_write),
        .req_src(req_src), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_byte_we(mem_byte_we), .mem_wdata(mem_wdata),
        .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data), .ld_cc(ld_cc)
    );

    function automatic logic [15:0] init_word(int i);
        return 16'(i * 16'h3A71 + 16'h0F0F);
    endfunction

    logic [15:0] mem [MEM_WORDS];
    logic [15:0] ref_mem [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_WORDS; i++) mem[i] <= init_word(i);
        end else begin
            if (mem_byte_we[0]) mem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
            if (mem_byte_we[1]) mem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
        end
    end
    assign mem_rdata = mem[mem_addr[8:1]];

    function automatic logic [15:0] calc_ea(logic [15:0] b, logic [5:0] o, logic by);
        logic [15:0] e;
        e = {{10{o[5]}}, o};
        return by ? b + e : b + (e << 1);
    endfunction

    function automatic logic [2:0] calc_cc(logic [15:0] d);
        if (d[15]) return 3'b100;
        if (d == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // pipeline of expectations
    logic        p1_v = 0, p1_w = 0, p1_b = 0;
    logic [15:0] p1_ea = 0, p1_src = 0;
    logic        p2_v = 0;
    logic [15:0] p2_data = 0;

    task automatic step(input logic v, input logic [15:0] b, input logic [5:0] o,
                        input logic by, input logic w, input logic [15:0] s);
        logic [15:0] word, exp_ld, exp_wd;
        logic [1:0]  exp_we;
        logic        ln;
        // stage 2: load result (R6, R7, R8, R11)
        if (p2_v) begin
            chk(ld_valid == 1'b1, "R6/R7 ld_valid", 16'(ld_valid), 16'h1);
            chk(ld_data == p2_data, "R6/R7 ld_data", ld_data, p2_data);
            chk(ld_cc == calc_cc(p2_data), "R8 ld_cc", 16'(ld_cc), 16'(calc_cc(p2_data)));
        end else begin
            chk(ld_valid == 1'b0, "R11 ld_valid idle", 16'(ld_valid), 16'h0);
        end
        // stage 1: memory side (R1, R2, R3, R4, R5, R9, R11)
        p2_v = 1'b0;
        if (p1_v) begin
            ln = p1_ea[0];
            chk(mem_req == 1'b1, "R2 mem_req", 16'(mem_req), 16'h1);
            chk(mem_addr == {p1_ea[15:1], 1'b0}, "R1/R2 mem_addr", mem_addr, {p1_ea[15:1], 1'b0});
            chk(misalign == (!p1_b && ln), "R9 misalign", 16'(misalign), 16'(!p1_b && ln));
            word = ref_mem[p1_ea[8:1]];
            if (p1_w) begin
                if (p1_b) begin
                    exp_we = ln ? 2'b10 : 2'b01;
                    exp_wd = {p1_src[7:0], p1_src[7:0]};
                    if (ln) ref_mem[p1_ea[8:1]][15:8] = p1_src[7:0];
                    else    ref_mem[p1_ea[8:1]][7:0]  = p1_src[7:0];
                    chk(mem_byte_we == exp_we, "R3 byte we", 16'(mem_byte_we), 16'(exp_we));
                    chk(mem_wdata == exp_wd, "R3 byte wdata", mem_wdata, exp_wd);
                end else begin
                    ref_mem[p1_ea[8:1]] = p1_src;
                    chk(mem_byte_we == 2'b11, "R4 word we", 16'(mem_byte_we), 16'h3);
                    chk(mem_wdata == p1_src, "R4 word wdata", mem_wdata, p1_src);
                end
            end else begin
                chk(mem_byte_we == 2'b00, "R5 load we", 16'(mem_byte_we), 16'h0);
                if (p1_b) exp_ld = ln ? {{8{word[15]}}, word[15:8]} : {{8{word[7]}}, word[7:0]};
                else      exp_ld = word;
                p2_v = 1'b1;
                p2_data = exp_ld;
            end
        end else begin
            chk(mem_req == 1'b0 && mem_byte_we == 2'b00, "R11 idle mem side",
                {mem_req, 13'h0, mem_byte_we}, 16'h0);
        end
        p1_v = v; p1_w = w; p1_b = by; p1_src = s;
        p1_ea = calc_ea(b, o, by);
        req_valid = v; req_base = b; req_off = o; req_byte = by;
        req_write = w; req_src = s;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < MEM_WORDS; i++) ref_mem[i] = init_word(i);
        repeat (3) @(negedge clk);
        // R10: outputs held low in reset
        chk(!mem_req && mem_byte_we == 0 && !misalign && !ld_valid, "R10 in reset",
            {mem_req, misalign, ld_valid, 11'h0, mem_byte_we}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req && mem_byte_we == 0 && !misalign && !ld_valid, "R10 after reset",
            {mem_req, misalign, ld_valid, 11'h0, mem_byte_we}, 16'h0);
        // directed: byte store both lanes, then read back word and bytes (R3, R6, R7)
        step(1, 16'h0040, 6'd0, 1, 1, 16'hAA80);
        step(1, 16'h0040, 6'd1, 1, 1, 16'h1234);
        step(1, 16'h0040, 6'd0, 0, 0, 16'h0);
        step(1, 16'h0040, 6'd0, 1, 0, 16'h0);
        step(1, 16'h0041, 6'd0, 1, 0, 16'h0);
        // store then load same word, load then store same word (R3, R6)
        step(1, 16'h0050, 6'd1, 1, 1, 16'h00FF);
        step(1, 16'h0051, 6'd0, 1, 0, 16'h0);
        step(1, 16'h0050, 6'd0, 0, 0, 16'h0);
        step(1, 16'h0050, 6'd0, 0, 1, 16'h0000);
        step(1, 16'h0050, 6'd0, 0, 0, 16'h0);  // R8 zero
        // negative offsets (R1), word scaled, byte unscaled
        step(1, 16'h0080, 6'h3F, 1, 0, 16'h0);
        step(1, 16'h0080, 6'h20, 0, 1, 16'h7FFF);
        step(1, 16'h0040, 6'h00, 0, 0, 16'h0);
        // misaligned word store and load (R9)
        step(1, 16'h0061, 6'd0, 0, 1, 16'hBEEF);
        step(1, 16'h0061, 6'd2, 0, 0, 16'h0);
        step(1, 16'h0060, 6'd0, 0, 0, 16'h0);
        // idle cycles (R11)
        step(0, 16'h0060, 6'd0, 0, 1, 16'hFFFF);
        step(0, 16'h0000, 6'd0, 1, 1, 16'h1111);
        step(1, 16'h0060, 6'd0, 0, 0, 16'h0);
        // random back-to-back traffic in a small window
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] rb;
            rb = 16'($urandom_range(16'h0020, 16'h003F));
            step(($urandom % 8) != 0, rb, 6'($urandom), 1'($urandom), 1'($urandom),
                 16'($urandom));
        end
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog expired t=%0t", $time);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule